// File: doc/BRIEF.md
# CCD Pixel Timing Sequencer

This block sits on the host side of a serial CCD digitizer. It runs from a fast system clock and produces every strobe the digitizer needs, one pixel at a time. Each pixel begins with a black-level clamp pulse. A video sample pulse follows after a guard gap. After a quiet interval, eight serial clocks read the conversion result MSB first from the shared data line. The result is placed in a parallel register and marked by a one-cycle valid pulse.

Between pixels the block can also reprogram the digitizer. A host pulse captures an 8-bit control word. At the next pixel boundary the block lowers the mode line and waits a turnaround time before it drives the data line. It then shifts the word out MSB first and pulses load. Finally it raises the mode line again and waits a second turnaround. Every pulse width, gap and turnaround is a parameter counted in system-clock cycles, and pixels are paced by a fixed period counter.

Top module: `ccd_pix_sequencer`

## Requirements
- R1: While reset is high and on the cycle after it is released, `dz_clamp`, `dz_vidsamp`, `dz_sclk`, `dz_load`, `dz_data_oe` and `pix_valid` are 0 and `dz_mode` is 1 (readout mode).
- R2: While `run` is high, successive rising edges of `dz_clamp` are exactly `PIX_PERIOD` cycles apart, including when a configuration write falls between the two pixels.
- R3: `dz_clamp` stays high for exactly `CLAMP_W` cycles, and `dz_vidsamp` rises exactly `GAP_W` cycles after the clamp falls; the two strobes are never high together.
- R4: `dz_vidsamp` stays high for exactly `SAMP_W` cycles. `dz_sclk` is low during the whole sample pulse, and the first readout serial clock rises exactly `QUIET_W + SCK_LO` cycles after the sample pulse falls.
- R5: Every transfer has exactly 8 serial clock rises. Each high phase lasts `SCK_HI` cycles and each low phase between two rises lasts `SCK_LO` cycles.
- R6: In readout, the digitizer presents bit k (bit 7 first) after the k-th rise. The block samples the line through a two-flop synchronizer `SAMP_DLY` cycles after each rise and assembles the bits MSB first. `pix_valid` is a single-cycle pulse, and `pix_data` then holds the full 8-bit word.
- R7: A one-cycle `cfg_req` captures `cfg_data`. In the configuration write, `dz_data_oe` rises exactly `MODE_TA` cycles after `dz_mode` falls. At each of the 8 rises, `dz_data_o` carries the next bit of the word (bit 7 first), and `dz_data_oe` is high only while `dz_mode` is low.
- R8: `dz_load` rises no sooner than `LD_GAP` cycles after the last write clock rise and stays high for exactly `LOAD_W` cycles. `dz_mode` returns high exactly `LD_GAP` cycles after load falls. No serial clock rises within `MODE_TA` cycles of any mode change.
- R9: A configuration request made during a pixel is deferred. `dz_mode` falls only after that pixel's `pix_valid`, and the clamp and sample strobes are only ever high while `dz_mode` is 1.
- R10: While `run` is low no new pixel starts, but a pending configuration write is still carried out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables periodic pixel capture |
| cfg_req | input | 1 | One-cycle request to write `cfg_data` |
| cfg_data | input | 8 | Control word for the digitizer |
| dz_data_i | input | 1 | Serial data from the digitizer (asynchronous) |
| dz_clamp | output | 1 | Black-level clamp strobe |
| dz_vidsamp | output | 1 | Video sample / conversion start strobe |
| dz_mode | output | 1 | 1 = readout, 0 = programming |
| dz_sclk | output | 1 | Serial clock |
| dz_load | output | 1 | Latches the shifted control word |
| dz_data_o | output | 1 | Serial data toward the digitizer |
| dz_data_oe | output | 1 | Drive enable for the shared data line |
| pix_data | output | 8 | Last assembled pixel word |
| pix_valid | output | 1 | One-cycle pulse marking new `pix_data` |

## Verification
All strobes are registered, so each edge appears one clock after the state change that causes it. The bench therefore measures widths and separations as exact differences between edge timestamps. It expects the clamp, sample and load widths and the mode-to-drive turnaround to equal their parameters. The first read clock is due `QUIET_W + SCK_LO` cycles after the sample strobe falls, and the pixel period is due at `PIX_PERIOD` cycles. The digitizer model changes its bit about 10.5 cycles after each clock rise, well clear of the sampling point. Outputs are sampled on falling clock edges, inputs are driven on falling edges, and tasks read the recorded timestamps on rising edges, so no check depends on the order of processes at an edge.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CLAMP, ST_GAP, ST_SAMP, ST_QUIET, ST_READ,
    ST_CTURN, ST_WRITE, ST_LDGAP, ST_LOAD, ST_LDEND, ST_BTURN
  } seq_state_t;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH, PH_TAIL} sh_phase_t;

  function automatic int cmax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter
  import ccd_seq_pkg::*;
#(
  parameter int BITS     = 8,
  parameter int SCK_HI   = 13,
  parameter int SCK_LO   = 13,
  parameter int SAMP_DLY = 18
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [BITS-1:0] wdata,
  input  logic            din,
  output logic            sclk,
  output logic            dout,
  output logic            done,
  output logic [BITS-1:0] rdata
);
  localparam int CW = $clog2(cmax(cmax(SCK_HI, SCK_LO), SAMP_DLY) + 1);
  localparam int BW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam int RW = $clog2(BITS + 1);

  sh_phase_t       ph;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bidx;
  logic [BITS-1:0] wreg;
  logic            smp_on;
  logic [CW-1:0]   smp_cnt;

  // Clock phases and write data
  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE; cnt <= '0; bidx <= '0; sclk <= 1'b0;
      dout <= 1'b0; wreg <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        PH_IDLE: if (start) begin
          ph   <= PH_LOW;
          cnt  <= CW'(SCK_LO - 1);
          bidx <= '0;
          dout <= wdata[BITS-1];
          wreg <= wdata << 1;
        end
        PH_LOW: if (cnt == '0) begin
          sclk <= 1'b1; ph <= PH_HIGH; cnt <= CW'(SCK_HI - 1);
        end else cnt <= cnt - 1'b1;
        PH_HIGH: if (cnt == '0) begin
          sclk <= 1'b0;
          cnt  <= CW'(SCK_LO - 1);
          if (bidx == BW'(BITS - 1)) ph <= PH_TAIL;
          else begin
            ph   <= PH_LOW;
            bidx <= bidx + 1'b1;
            dout <= wreg[BITS-1];
            wreg <= wreg << 1;
          end
        end else cnt <= cnt - 1'b1;
        PH_TAIL: if (cnt == '0) begin
          ph <= PH_IDLE; done <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // Delayed read sampling, armed at every rise
  always_ff @(posedge clk) begin
    if (rst) begin
      smp_on <= 1'b0; smp_cnt <= '0; rdata <= '0;
    end else if (ph == PH_LOW && cnt == '0) begin
      smp_on <= 1'b1; smp_cnt <= CW'(SAMP_DLY - 1);
    end else if (smp_on) begin
      if (smp_cnt == '0) begin
        rdata  <= {rdata[BITS-2:0], din};
        smp_on <= 1'b0;
      end else smp_cnt <= smp_cnt - 1'b1;
    end
  end

  // Independent observers of the serial clock
  logic [CW-1:0] hi_len;
  logic [RW-1:0] rcnt;
  logic          sclk_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_len <= '0; rcnt <= '0; sclk_q <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (sclk) begin
        if (hi_len != '1) hi_len <= hi_len + 1'b1;
      end else hi_len <= '0;
      if (done) rcnt <= '0;
      else if (sclk && !sclk_q) rcnt <= rcnt + 1'b1;
    end
  end

  p_sclk_high_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> hi_len == CW'(SCK_HI));
  p_rise_limit_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> rcnt < RW'(BITS));
  p_done_count_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> rcnt == RW'(BITS));
endmodule

// File: rtl/ccd_pix_sequencer.sv
module ccd_pix_sequencer
  import ccd_seq_pkg::*;
#(
  parameter int DW         = 8,
  parameter int PIX_PERIOD = 1000,
  parameter int CLAMP_W    = 75,
  parameter int GAP_W      = 13,
  parameter int SAMP_W     = 125,
  parameter int QUIET_W    = 13,
  parameter int SCK_HI     = 13,
  parameter int SCK_LO     = 13,
  parameter int SAMP_DLY   = 18,
  parameter int MODE_TA    = 13,
  parameter int LD_GAP     = 13,
  parameter int LOAD_W     = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          cfg_req,
  input  logic [DW-1:0] cfg_data,
  input  logic          dz_data_i,
  output logic          dz_clamp,
  output logic          dz_vidsamp,
  output logic          dz_mode,
  output logic          dz_sclk,
  output logic          dz_load,
  output logic          dz_data_o,
  output logic          dz_data_oe,
  output logic [DW-1:0] pix_data,
  output logic          pix_valid
);
  localparam int TW  = $clog2(cmax(cmax(cmax(CLAMP_W, SAMP_W), cmax(GAP_W, QUIET_W)),
                                   cmax(cmax(MODE_TA, LD_GAP), LOAD_W)) + 1);
  localparam int PW  = $clog2(PIX_PERIOD + 1);
  localparam int TAW = $clog2(MODE_TA + 1);

  seq_state_t    state, state_n;
  logic          tmr_ld, tmr_exp, sh_go, sh_done;
  logic [TW-1:0] tmr_val;
  logic [DW-1:0] sh_rdata, cfg_word;
  logic [PW-1:0] per_cnt;
  logic          pix_pend, cfg_pend;
  logic [1:0]    din_sync;

  seq_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_ld), .val(tmr_val), .expired(tmr_exp));

  ser_shifter #(.BITS(DW), .SCK_HI(SCK_HI), .SCK_LO(SCK_LO), .SAMP_DLY(SAMP_DLY)) u_shf (
    .clk(clk), .rst(rst), .start(sh_go), .wdata(cfg_word), .din(din_sync[1]),
    .sclk(dz_sclk), .dout(dz_data_o), .done(sh_done), .rdata(sh_rdata));

  // Pixel pacing and pending requests
  always_ff @(posedge clk) begin
    if (rst) begin
      per_cnt <= '0; pix_pend <= 1'b0; cfg_pend <= 1'b0; cfg_word <= '0; din_sync <= '0;
    end else begin
      din_sync <= {din_sync[0], dz_data_i};
      if (state == ST_IDLE && state_n == ST_CLAMP) pix_pend <= 1'b0;
      if (!run) begin
        per_cnt  <= '0;
        pix_pend <= 1'b0;
      end else if (per_cnt == '0) begin
        per_cnt  <= PW'(PIX_PERIOD - 1);
        pix_pend <= 1'b1;
      end else per_cnt <= per_cnt - 1'b1;
      if (state == ST_IDLE && state_n == ST_CTURN) cfg_pend <= 1'b0;
      if (cfg_req) begin
        cfg_pend <= 1'b1;
        cfg_word <= cfg_data;
      end
    end
  end

  // Sequencing
  always_comb begin
    state_n = state;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    sh_go   = 1'b0;
    unique case (state)
      ST_IDLE:
        if (pix_pend) begin
          state_n = ST_CLAMP; tmr_ld = 1'b1; tmr_val = TW'(CLAMP_W - 1);
        end else if (cfg_pend) begin
          state_n = ST_CTURN; tmr_ld = 1'b1; tmr_val = TW'(MODE_TA - 1);
        end
      ST_CLAMP: if (tmr_exp) begin state_n = ST_GAP;   tmr_ld = 1'b1; tmr_val = TW'(GAP_W - 1);   end
      ST_GAP:   if (tmr_exp) begin state_n = ST_SAMP;  tmr_ld = 1'b1; tmr_val = TW'(SAMP_W - 1);  end
      ST_SAMP:  if (tmr_exp) begin state_n = ST_QUIET; tmr_ld = 1'b1; tmr_val = TW'(QUIET_W - 1); end
      ST_QUIET: if (tmr_exp) begin state_n = ST_READ;  sh_go = 1'b1; end
      ST_READ:  if (sh_done) state_n = ST_IDLE;
      ST_CTURN: if (tmr_exp) begin state_n = ST_WRITE; sh_go = 1'b1; end
      ST_WRITE: if (sh_done) begin state_n = ST_LDGAP; tmr_ld = 1'b1; tmr_val = TW'(LD_GAP - 1);  end
      ST_LDGAP: if (tmr_exp) begin state_n = ST_LOAD;  tmr_ld = 1'b1; tmr_val = TW'(LOAD_W - 1);  end
      ST_LOAD:  if (tmr_exp) begin state_n = ST_LDEND; tmr_ld = 1'b1; tmr_val = TW'(LD_GAP - 1);  end
      ST_LDEND: if (tmr_exp) begin state_n = ST_BTURN; tmr_ld = 1'b1; tmr_val = TW'(MODE_TA - 1); end
      ST_BTURN: if (tmr_exp) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  // Registered strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; dz_clamp <= 1'b0; dz_vidsamp <= 1'b0; dz_load <= 1'b0;
      dz_data_oe <= 1'b0; dz_mode <= 1'b1; pix_valid <= 1'b0; pix_data <= '0;
    end else begin
      state      <= state_n;
      dz_clamp   <= (state_n == ST_CLAMP);
      dz_vidsamp <= (state_n == ST_SAMP);
      dz_load    <= (state_n == ST_LOAD);
      dz_data_oe <= (state_n == ST_WRITE);
      dz_mode    <= !(state_n inside {ST_CTURN, ST_WRITE, ST_LDGAP, ST_LOAD, ST_LDEND});
      pix_valid  <= (state == ST_READ) && sh_done;
      if ((state == ST_READ) && sh_done) pix_data <= sh_rdata;
    end
  end

  // Observer: cycles since the last mode change
  logic           mode_q;
  logic [TAW-1:0] ta_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b1; ta_cnt <= '0;
    end else begin
      mode_q <= dz_mode;
      if (dz_mode != mode_q) ta_cnt <= '0;
      else if (ta_cnt != TAW'(MODE_TA)) ta_cnt <= ta_cnt + 1'b1;
    end
  end

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(dz_clamp && dz_vidsamp));
  p_quiet_sclk_r4: assert property (@(posedge clk) disable iff (rst)
    dz_vidsamp |-> !dz_sclk);
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> !pix_valid);
  p_oe_prog_r7: assert property (@(posedge clk) disable iff (rst)
    dz_data_oe |-> !dz_mode);
  p_load_prog_r8: assert property (@(posedge clk) disable iff (rst)
    dz_load |-> !dz_mode);
  p_mode_ta_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(dz_sclk) |-> ta_cnt == TAW'(MODE_TA));
  p_strobe_readout_r9: assert property (@(posedge clk) disable iff (rst)
    (dz_clamp || dz_vidsamp) |-> dz_mode);
endmodule

// File: tb/ccd_pix_sequencer_tb.sv
module ccd_pix_sequencer_tb_top;
  localparam int PIX_PERIOD = 1000;
  localparam int CLAMP_W = 75, GAP_W = 13, SAMP_W = 125, QUIET_W = 13;
  localparam int SCK_HI = 13, SCK_LO = 13, SAMP_DLY = 18;
  localparam int MODE_TA = 13, LD_GAP = 13, LOAD_W = 13;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, run = 1'b0, cfg_req = 1'b0, dz_data_i = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic dz_clamp, dz_vidsamp, dz_mode, dz_sclk, dz_load, dz_data_o, dz_data_oe, pix_valid;
  logic [7:0] pix_data;

  ccd_pix_sequencer #(
    .DW(8), .PIX_PERIOD(PIX_PERIOD), .CLAMP_W(CLAMP_W), .GAP_W(GAP_W), .SAMP_W(SAMP_W),
    .QUIET_W(QUIET_W), .SCK_HI(SCK_HI), .SCK_LO(SCK_LO), .SAMP_DLY(SAMP_DLY),
    .MODE_TA(MODE_TA), .LD_GAP(LD_GAP), .LOAD_W(LOAD_W)
  ) dut_i (
    .clk(clk), .rst(rst), .run(run), .cfg_req(cfg_req), .cfg_data(cfg_data),
    .dz_data_i(dz_data_i), .dz_clamp(dz_clamp), .dz_vidsamp(dz_vidsamp), .dz_mode(dz_mode),
    .dz_sclk(dz_sclk), .dz_load(dz_load), .dz_data_o(dz_data_o), .dz_data_oe(dz_data_oe),
    .pix_data(pix_data), .pix_valid(pix_valid));

  int cyc = 0;
  always @(posedge clk) cyc++;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Test words returned by the digitizer model, one per sample strobe
  logic [7:0] words [0:7];
  initial begin
    words[0] = 8'hA5; words[1] = 8'h00; words[2] = 8'hFF; words[3] = 8'h3C;
    words[4] = 8'h81; words[5] = 8'h7E; words[6] = 8'h5A; words[7] = 8'hC3;
  end

  // Edge monitor, sampled on falling clock edges
  bit p_clamp, p_vid, p_sclk, p_mode = 1'b1, p_oe, p_load, p_valid;
  int t_crise = -1, t_cfall = 0, t_vrise = 0, t_vfall = 0, t_srise = 0, t_sfall = 0;
  int t_mfall = 0, t_mrise = 0, t_oerise = 0, t_lrise = 0, t_valid = 0;
  int clamp_w, gap_w, samp_w, per_last, first_dly, load_w, ld_gap;
  int n_crise = 0, n_valid = 0, n_loads = 0, valid_dbl = 0, wr_idx = 0;
  int rd_rises = 0, cfg_bits = 0, oe_bad = 0;
  int hi_min, hi_max, lo_min, lo_max;
  logic [7:0] cur_word = 8'h00, cfg_cap = 8'h00, got_data = 8'h00;

  always @(negedge clk) begin
    if (dz_clamp && !p_clamp) begin
      if (t_crise >= 0) per_last = cyc - t_crise;
      t_crise = cyc; n_crise++;
    end
    if (!dz_clamp && p_clamp) begin clamp_w = cyc - t_crise; t_cfall = cyc; end
    if (dz_vidsamp && !p_vid) begin gap_w = cyc - t_cfall; t_vrise = cyc; end
    if (!dz_vidsamp && p_vid) begin
      samp_w = cyc - t_vrise; t_vfall = cyc;
      cur_word = words[wr_idx % 8]; wr_idx++;
      rd_rises = 0; first_dly = -1;
      hi_min = 1000000; hi_max = 0; lo_min = 1000000; lo_max = 0;
    end
    if (!dz_mode && p_mode) begin
      t_mfall = cyc; cfg_bits = 0; cfg_cap = 8'h00; oe_bad = 0;
      hi_min = 1000000; hi_max = 0; lo_min = 1000000; lo_max = 0;
    end
    if (dz_mode && !p_mode) t_mrise = cyc;
    if (dz_data_oe && !p_oe) t_oerise = cyc;
    if (dz_sclk && !p_sclk) begin
      bit first;
      if (dz_mode) begin
        rd_rises++;
        if (rd_rises == 1) first_dly = cyc - t_vfall;
        first = (rd_rises == 1);
      end else begin
        cfg_cap = {cfg_cap[6:0], dz_data_o}; cfg_bits++;
        if (!dz_data_oe) oe_bad++;
        first = (cfg_bits == 1);
      end
      if (!first) begin
        if (cyc - t_sfall < lo_min) lo_min = cyc - t_sfall;
        if (cyc - t_sfall > lo_max) lo_max = cyc - t_sfall;
      end
      t_srise = cyc;
    end
    if (!dz_sclk && p_sclk) begin
      if (cyc - t_srise < hi_min) hi_min = cyc - t_srise;
      if (cyc - t_srise > hi_max) hi_max = cyc - t_srise;
      t_sfall = cyc;
    end
    if (dz_load && !p_load) begin t_lrise = cyc; ld_gap = cyc - t_srise; end
    if (!dz_load && p_load) begin load_w = cyc - t_lrise; n_loads++; end
    if (pix_valid) begin
      if (p_valid) valid_dbl++;
      else begin t_valid = cyc; got_data = pix_data; n_valid++; end
    end
    p_clamp = dz_clamp; p_vid = dz_vidsamp; p_sclk = dz_sclk; p_mode = dz_mode;
    p_oe = dz_data_oe; p_load = dz_load; p_valid = pix_valid;
  end

  // Digitizer model: bit k appears about 42 ns after the k-th rise in readout
  always @(posedge dz_sclk) begin
    if (dz_mode) begin
      #42;
      if (rd_rises >= 1 && rd_rises <= 8) dz_data_i = cur_word[8 - rd_rises];
    end
  end

  task automatic wait_valid();
    int n0 = n_valid;
    while (n_valid == n0) @(posedge clk);
  endtask

  task automatic check_pixel(input int idx, input bit chk_period);
    chk(got_data == words[idx % 8], "R6", "pixel word", got_data, words[idx % 8]);
    chk(clamp_w == CLAMP_W, "R3", "clamp width", clamp_w, CLAMP_W);
    chk(gap_w == GAP_W, "R3", "clamp-to-sample gap", gap_w, GAP_W);
    chk(samp_w == SAMP_W, "R4", "sample width", samp_w, SAMP_W);
    chk(first_dly == QUIET_W + SCK_LO, "R4", "sample fall to first rise", first_dly, QUIET_W + SCK_LO);
    chk(rd_rises == 8, "R5", "read clock rises", rd_rises, 8);
    chk(hi_min == SCK_HI && hi_max == SCK_HI, "R5", "read clock high", hi_max, SCK_HI);
    chk(lo_min == SCK_LO && lo_max == SCK_LO, "R5", "read clock low", lo_max, SCK_LO);
    if (chk_period) chk(per_last == PIX_PERIOD, "R2", "pixel period", per_last, PIX_PERIOD);
  endtask

  task automatic t_reset_r1();
    rst = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(!dz_clamp && !dz_vidsamp && !dz_sclk, "R1", "strobes in reset", {dz_clamp, dz_vidsamp, dz_sclk}, 0);
    chk(!dz_load && !dz_data_oe && !pix_valid, "R1", "load/oe/valid in reset", {dz_load, dz_data_oe, pix_valid}, 0);
    chk(dz_mode == 1'b1, "R1", "mode in reset", dz_mode, 1);
    rst = 1'b0;
    @(negedge clk);
    chk(dz_mode && !dz_clamp && !dz_sclk && !pix_valid, "R1", "state after release",
        {dz_mode, dz_clamp, dz_sclk, pix_valid}, 8);
  endtask

  task automatic t_pixels_r2(input int n);
    int base = wr_idx;
    @(negedge clk); run = 1'b1;
    for (int i = 0; i < n; i++) begin
      wait_valid();
      check_pixel(base + i, i > 0);
    end
    @(negedge clk); run = 1'b0;
    repeat (4) @(posedge clk);
    chk(valid_dbl == 0, "R6", "valid pulse length", valid_dbl, 0);
  endtask

  task automatic t_cfg_idle_r10(input logic [7:0] w);
    int nc, nl;
    repeat (1200) @(posedge clk);
    nc = n_crise; nl = n_loads;
    @(negedge clk); cfg_data = w; cfg_req = 1'b1;
    @(negedge clk); cfg_req = 1'b0; cfg_data = 8'h00;
    while (n_loads == nl) @(posedge clk);
    while (t_mrise < t_lrise) @(posedge clk);
    chk(cfg_cap == w && cfg_bits == 8, "R7", "shifted control word", cfg_cap, w);
    chk(oe_bad == 0, "R7", "drive enable at write rises", oe_bad, 0);
    chk(t_oerise - t_mfall == MODE_TA, "R7", "mode fall to drive", t_oerise - t_mfall, MODE_TA);
    chk(hi_max == SCK_HI && lo_max == SCK_LO && lo_min == SCK_LO, "R5", "write clock phases", hi_max, SCK_HI);
    chk(load_w == LOAD_W, "R8", "load width", load_w, LOAD_W);
    chk(ld_gap >= LD_GAP, "R8", "last rise to load", ld_gap, LD_GAP);
    chk(t_mrise - (t_lrise + load_w) == LD_GAP, "R8", "load fall to mode rise",
        t_mrise - (t_lrise + load_w), LD_GAP);
    repeat (1500) @(posedge clk);
    chk(n_crise == nc, "R10", "no pixel while run low", n_crise - nc, 0);
  endtask

  task automatic t_cfg_in_pixel_r9();
    int nc = n_crise, nl = n_loads, base = wr_idx;
    @(negedge clk); run = 1'b1;
    while (n_crise == nc) @(posedge clk);
    @(negedge clk); cfg_data = 8'h5A; cfg_req = 1'b1;
    @(negedge clk); cfg_req = 1'b0; cfg_data = 8'h00;
    wait_valid();
    check_pixel(base, 1'b0);
    while (n_loads == nl) @(posedge clk);
    chk(t_mfall > t_valid, "R9", "mode drop after pixel valid", t_mfall, t_valid + 1);
    chk(cfg_cap == 8'h5A, "R7", "deferred control word", cfg_cap, 8'h5A);
    wait_valid();
    check_pixel(base + 1, 1'b1);
    @(negedge clk); run = 1'b0;
  endtask

  initial begin
    t_reset_r1();
    t_pixels_r2(5);
    t_cfg_idle_r10(8'hC3);
    t_cfg_idle_r10(8'h81);
    t_cfg_in_pixel_r9();
    repeat (20) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule